// File: doc/BRIEF.md
# Banked UART Register Decoder

This block is the host-facing register file and address decoder for a single UART channel. A host drives a 3-bit address, a chip select and read and write strobes, and exchanges 8-bit data. The block holds the channel's configuration registers: line control, modem control, enhanced features, interrupt enable, scratch byte, the two divisor bytes, two start and two stop flow-control characters, transmit-control thresholds and trigger levels. It presents them on output ports so a UART core can use them.

The receive and transmit data, line and modem status, interrupt identification and FIFO control locations are not stored here. For those the block raises a one-cycle strobe towards the external core and passes the data through. The same address can reach different registers. Which one it reaches depends on the stored line control value, the enhanced-feature enable bit and a modem control bit. A fixed precedence settles the cases where more than one bank condition holds.

Top module: `uart_rb_dec`

## Requirements
- R1: After reset, line control, modem control, enhanced feature, interrupt enable, both divisor bytes, all four flow characters, transmit-control, trigger-level and scratch registers are 00h. `rdata` is 00h and no core strobe is raised while `cs` is 0.
- R2: In the default bank (line control bit 7 = 0, no other bank active), reads of addresses 0 to 7 return, in address order: core receive byte, interrupt enable, core interrupt-id byte, line control, modem control, core line status, core modem status, scratch.
- R3: In the default bank, a write to address 0 raises `core_thr_wr` and a write to address 2 raises `core_fcr_wr`, each with `core_wdata` equal to `wdata`. Addresses 1, 3, 4 and 7 write interrupt enable, line control, modem control and scratch. Writes to addresses 5 and 6 change no register.
- R4: While line control bit 7 is 1, addresses 0 and 1 read and write the low and high divisor bytes. No receive or transmit strobe is raised for them.
- R5: While line control equals BFh exactly, address 2 reads and writes the enhanced feature register and addresses 4 to 7 read and write start char 1, start char 2, stop char 1 and stop char 2. This bank takes precedence over every other condition, and addresses 0 and 1 remain the divisor bytes.
- R6: When line control is not BFh and both enhanced feature bit 4 and modem control bit 6 are 1, address 6 reads and writes the transmit-control register and address 7 the trigger-level register.
- R7: A modem control write updates bit 7 only when enhanced feature bit 4 is 1; otherwise bit 7 keeps its value while bits 6:0 take the written data.
- R8: A default-bank read of address 7 returns `core_fifo_rdy` instead of scratch when modem control bit 2 is 1 and bit 4 is 0. Writes to address 7 still go to scratch.
- R9: `core_rhr_rd`, `core_iir_rd`, `core_lsr_rd` and `core_msr_rd` are high only in a cycle with a read access of that default-bank location. `core_thr_wr` and `core_fcr_wr` are high only in a cycle with a write access of that location. At most one strobe is high at a time, and a cycle with both `rd_en` and `wr_en` counts as a write.
- R10: Address 3 reads and writes line control in every bank, and the written value is visible on `lcr_o` the next cycle.
- R11: The stored registers appear on output ports: `div_o` = {high, low}, `xon_o` = {char 2, char 1}, `xoff_o` = {char 2, char 1}, plus `lcr_o`, `mcr_o`, `efr_o`, `ier_o`, `tcr_o` and `tlr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read access strobe |
| wr_en | input | 1 | Write access strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| core_rx_data | input | 8 | Receive byte from the core |
| core_iir | input | 8 | Interrupt-id byte from the core |
| core_lsr | input | 8 | Line status byte from the core |
| core_msr | input | 8 | Modem status byte from the core |
| core_fifo_rdy | input | 8 | FIFO-ready status byte from the core |
| core_rhr_rd | output | 1 | Receive byte read strobe |
| core_iir_rd | output | 1 | Interrupt-id read strobe |
| core_lsr_rd | output | 1 | Line status read strobe |
| core_msr_rd | output | 1 | Modem status read strobe |
| core_thr_wr | output | 1 | Transmit byte write strobe |
| core_fcr_wr | output | 1 | FIFO control write strobe |
| core_wdata | output | 8 | Data passed with the write strobes |
| lcr_o | output | 8 | Line control register |
| mcr_o | output | 8 | Modem control register |
| efr_o | output | 8 | Enhanced feature register |
| ier_o | output | 8 | Interrupt enable register |
| div_o | output | 16 | Divisor {high, low} |
| xon_o | output | 16 | Start chars {2, 1} |
| xoff_o | output | 16 | Stop chars {2, 1} |
| tcr_o | output | 8 | Transmit-control register |
| tlr_o | output | 8 | Trigger-level register |

## Verification
The bench walks the banks in a sequence where the conditions overlap. The enhanced bit is set while modem control bit 6 is already 1 and line control is BFh, so a decoder with the wrong precedence would return the transmit-control byte where stop char 1 belongs. Each bank is followed by a full default-bank readback, so a hidden write that leaks into interrupt enable or scratch shows up as a wrong byte. It also checks that the modem control top bit holds when the enhanced bit is 0, which a decoder without that protection would overwrite. Strobes are compared on every access, which catches a banked alias at address 0 or 2 that still fires the transmit or FIFO strobe.

// File: rtl/uart_rb_pkg.sv
// Package: shared constants and the decoded-target type for the banked
// UART register decoder. Assumes an 8-bit data path and 3-bit address.
package uart_rb_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 3;
    localparam int NUM_CHARS   = 4;
    localparam logic [DATA_W-1:0] LCR_KEY = 8'hBF;
    localparam int LCR_DIV_BIT = 7;
    localparam int EFR_ENH_BIT = 4;
    localparam int MCR_TCR_BIT = 6;
    localparam int MCR_LOCK_BIT = 7;
    localparam int MCR_RDY_BIT = 2;
    localparam int MCR_LOOP_BIT = 4;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_DATA, SEL_IER, SEL_IDFC, SEL_LCR, SEL_MCR,
        SEL_LSR, SEL_MSR, SEL_SPR, SEL_FRDY, SEL_DLL, SEL_DLM, SEL_EFR,
        SEL_XON1, SEL_XON2, SEL_XOFF1, SEL_XOFF2, SEL_TCR, SEL_TLR
    } sel_e;
endpackage

// File: rtl/uart_rb_bank_sel.sv
// Bank selector: maps an address plus stored register state to one target.
// Precedence: LCR key bank, then TCR/TLR bank, then divisor bank, then default.
// Assumes IS_WR picks write-side targets (no target at 5/6, scratch at 7).
module uart_rb_bank_sel
    import uart_rb_pkg::*;
#(
    parameter bit IS_WR = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lcr,
    input  logic [DATA_W-1:0] mcr,
    input  logic [DATA_W-1:0] efr,
    output sel_e              sel
);
    logic key_bank, tcr_bank, div_bank, rdy_ok;

    // Purpose: derive the bank conditions from stored state.
    always_comb begin
        key_bank = (lcr == LCR_KEY);
        tcr_bank = efr[EFR_ENH_BIT] && mcr[MCR_TCR_BIT];
        div_bank = lcr[LCR_DIV_BIT];
        rdy_ok   = mcr[MCR_RDY_BIT] && !mcr[MCR_LOOP_BIT];
    end

    // Purpose: resolve the address to a single target by precedence.
    always_comb begin
        sel = SEL_NONE;
        case (addr)
            3'd0: sel = div_bank ? SEL_DLL : SEL_DATA;
            3'd1: sel = div_bank ? SEL_DLM : SEL_IER;
            3'd2: sel = key_bank ? SEL_EFR : SEL_IDFC;
            3'd3: sel = SEL_LCR;
            3'd4: sel = key_bank ? SEL_XON1 : SEL_MCR;
            3'd5: sel = key_bank ? SEL_XON2 : (IS_WR ? SEL_NONE : SEL_LSR);
            3'd6: sel = key_bank ? SEL_XOFF1 : tcr_bank ? SEL_TCR
                      : (IS_WR ? SEL_NONE : SEL_MSR);
            default: sel = key_bank ? SEL_XOFF2 : tcr_bank ? SEL_TLR
                      : ((!IS_WR && rdy_ok) ? SEL_FRDY : SEL_SPR);
        endcase
    end
endmodule

// File: rtl/uart_rb_store.sv
// Register storage: holds every host-visible configuration register and
// applies writes for the decoded target. Assumes `we` is a qualified access.
module uart_rb_store
    import uart_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lcr,
    output logic [DATA_W-1:0] mcr,
    output logic [DATA_W-1:0] efr,
    output logic [DATA_W-1:0] ier,
    output logic [DATA_W-1:0] spr,
    output logic [DATA_W-1:0] dll,
    output logic [DATA_W-1:0] dlm,
    output logic [DATA_W-1:0] tcr,
    output logic [DATA_W-1:0] tlr,
    output logic [NUM_CHARS*DATA_W-1:0] chars
);
    // Purpose: update the scalar registers on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr <= '0; mcr <= '0; efr <= '0; ier <= '0; spr <= '0;
            dll <= '0; dlm <= '0; tcr <= '0; tlr <= '0;
        end else if (we) begin
            case (sel)
                SEL_LCR: lcr <= wdata;
                SEL_MCR: begin
                    mcr <= wdata;
                    if (!efr[EFR_ENH_BIT]) mcr[MCR_LOCK_BIT] <= mcr[MCR_LOCK_BIT];
                end
                SEL_EFR: efr <= wdata;
                SEL_IER: ier <= wdata;
                SEL_SPR: spr <= wdata;
                SEL_DLL: dll <= wdata;
                SEL_DLM: dlm <= wdata;
                SEL_TCR: tcr <= wdata;
                SEL_TLR: tlr <= wdata;
                default: ;
            endcase
        end
    end

    // One slot per flow character; slot i answers to target SEL_XON1 + i.
    for (genvar i = 0; i < NUM_CHARS; i++) begin : g_char
        localparam sel_e MY_SEL = sel_e'(int'(SEL_XON1) + i);
        // Purpose: store flow character i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chars[i*DATA_W +: DATA_W] <= '0;
            else if (we && sel == MY_SEL)
                chars[i*DATA_W +: DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/uart_rb_rmux.sv
// Read multiplexer: returns the byte of the decoded read target, or zero
// when chip select is low. Assumes pass-through bytes come from the core.
module uart_rb_rmux
    import uart_rb_pkg::*;
(
    input  logic              cs,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] lcr, mcr, efr, ier, spr, dll, dlm, tcr, tlr,
    input  logic [NUM_CHARS*DATA_W-1:0] chars,
    input  logic [DATA_W-1:0] rx_data, iir, lsr, msr, fifo_rdy,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mux;

    // Purpose: choose the byte for the selected target.
    always_comb begin
        case (sel)
            SEL_DATA:  mux = rx_data;
            SEL_IER:   mux = ier;
            SEL_IDFC:  mux = iir;
            SEL_LCR:   mux = lcr;
            SEL_MCR:   mux = mcr;
            SEL_LSR:   mux = lsr;
            SEL_MSR:   mux = msr;
            SEL_SPR:   mux = spr;
            SEL_FRDY:  mux = fifo_rdy;
            SEL_DLL:   mux = dll;
            SEL_DLM:   mux = dlm;
            SEL_EFR:   mux = efr;
            SEL_XON1:  mux = chars[0*DATA_W +: DATA_W];
            SEL_XON2:  mux = chars[1*DATA_W +: DATA_W];
            SEL_XOFF1: mux = chars[2*DATA_W +: DATA_W];
            SEL_XOFF2: mux = chars[3*DATA_W +: DATA_W];
            SEL_TCR:   mux = tcr;
            SEL_TLR:   mux = tlr;
            default:   mux = '0;
        endcase
    end

    // Purpose: force zero while the chip is not selected.
    always_comb rdata = cs ? mux : '0;
endmodule

// File: rtl/uart_rb_dec.sv
// Top: banked register decoder for one UART channel. Decodes read and
// write targets separately, stores configuration, raises core strobes.
// Assumes a write wins when rd_en and wr_en are high together.
module uart_rb_dec
    import uart_rb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs,
    input  logic        rd_en,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  core_rx_data,
    input  logic [7:0]  core_iir,
    input  logic [7:0]  core_lsr,
    input  logic [7:0]  core_msr,
    input  logic [7:0]  core_fifo_rdy,
    output logic        core_rhr_rd,
    output logic        core_iir_rd,
    output logic        core_lsr_rd,
    output logic        core_msr_rd,
    output logic        core_thr_wr,
    output logic        core_fcr_wr,
    output logic [7:0]  core_wdata,
    output logic [7:0]  lcr_o,
    output logic [7:0]  mcr_o,
    output logic [7:0]  efr_o,
    output logic [7:0]  ier_o,
    output logic [15:0] div_o,
    output logic [15:0] xon_o,
    output logic [15:0] xoff_o,
    output logic [7:0]  tcr_o,
    output logic [7:0]  tlr_o
);
    sel_e rd_sel, wr_sel;
    logic rd_acc, wr_acc;
    logic [DATA_W-1:0] spr, dll, dlm;
    logic [NUM_CHARS*DATA_W-1:0] chars;

    // Purpose: qualify host accesses; a write takes priority.
    always_comb begin
        wr_acc = cs && wr_en;
        rd_acc = cs && rd_en && !wr_en;
    end

    uart_rb_bank_sel #(.IS_WR(1'b0)) rsel_i (
        .addr(addr), .lcr(lcr_o), .mcr(mcr_o), .efr(efr_o), .sel(rd_sel));
    uart_rb_bank_sel #(.IS_WR(1'b1)) wsel_i (
        .addr(addr), .lcr(lcr_o), .mcr(mcr_o), .efr(efr_o), .sel(wr_sel));

    uart_rb_store store_i (
        .clk(clk), .rst_n(rst_n), .we(wr_acc), .sel(wr_sel), .wdata(wdata),
        .lcr(lcr_o), .mcr(mcr_o), .efr(efr_o), .ier(ier_o), .spr(spr),
        .dll(dll), .dlm(dlm), .tcr(tcr_o), .tlr(tlr_o), .chars(chars));

    uart_rb_rmux rmux_i (
        .cs(cs), .sel(rd_sel), .lcr(lcr_o), .mcr(mcr_o), .efr(efr_o),
        .ier(ier_o), .spr(spr), .dll(dll), .dlm(dlm), .tcr(tcr_o),
        .tlr(tlr_o), .chars(chars), .rx_data(core_rx_data), .iir(core_iir),
        .lsr(core_lsr), .msr(core_msr), .fifo_rdy(core_fifo_rdy),
        .rdata(rdata));

    // Purpose: raise pass-through strobes for default-bank core locations.
    always_comb begin
        core_rhr_rd = rd_acc && rd_sel == SEL_DATA;
        core_iir_rd = rd_acc && rd_sel == SEL_IDFC;
        core_lsr_rd = rd_acc && rd_sel == SEL_LSR;
        core_msr_rd = rd_acc && rd_sel == SEL_MSR;
        core_thr_wr = wr_acc && wr_sel == SEL_DATA;
        core_fcr_wr = wr_acc && wr_sel == SEL_IDFC;
        core_wdata  = wdata;
    end

    // Purpose: pack paired registers onto their output ports.
    always_comb begin
        div_o  = {dlm, dll};
        xon_o  = chars[2*DATA_W-1:0];
        xoff_o = chars[4*DATA_W-1:2*DATA_W];
    end
endmodule

// File: rtl/uart_rb_chk.sv
// Checker: port-level properties of the banked decoder, bound to the top.
module uart_rb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] lcr_o,
    input logic [7:0] mcr_o,
    input logic [7:0] efr_o,
    input logic [5:0] strb
);
    a_r7_lock_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && addr == 3'd4 && lcr_o != 8'hBF && !efr_o[4])
        |=> (mcr_o[7] == $past(mcr_o[7])));
    a_r10_lcr_any_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && addr == 3'd3) |=> (lcr_o == $past(wdata)));
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));
    a_r4_no_thr_div: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && addr == 3'd0 && lcr_o[7]) |-> !strb[1]);
    a_r5_no_fcr_key: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_en && addr == 3'd2 && lcr_o == 8'hBF) |-> !strb[0]);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (rdata == 8'h00 && strb == 6'b0));
endmodule

bind uart_rb_dec uart_rb_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .lcr_o(lcr_o), .mcr_o(mcr_o),
    .efr_o(efr_o),
    .strb({core_rhr_rd, core_iir_rd, core_lsr_rd, core_msr_rd,
           core_thr_wr, core_fcr_wr}));

// File: tb/uart_rb_dec_tb_top.sv
`timescale 1ns/1ps
module uart_rb_dec_tb_top;
    logic clk = 0, rst_n = 0, cs = 0, rd_en = 0, wr_en = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata, core_wdata;
    logic [7:0] lcr_o, mcr_o, efr_o, ier_o, tcr_o, tlr_o;
    logic [15:0] div_o, xon_o, xoff_o;
    logic rhr, iir, lsr, msr, thr, fcr;
    logic [5:0] strb;
    localparam logic [7:0] RX = 8'hA1, IIRV = 8'hC2, LSRV = 8'h60,
                           MSRV = 8'hB3, RDY = 8'h5E;
    int n_tests = 0, n_fail = 0;
    // bench model of the registers
    logic [7:0] m_lcr = 0, m_mcr = 0, m_efr = 0, m_ier = 0, m_spr = 0,
                m_dll = 0, m_dlm = 0, m_tcr = 0, m_tlr = 0;
    logic [7:0] m_ch [4] = '{default: 8'h00};

    always #10 clk = ~clk;
    assign strb = {rhr, iir, lsr, msr, thr, fcr};

    uart_rb_dec dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .core_rx_data(RX),
        .core_iir(IIRV), .core_lsr(LSRV), .core_msr(MSRV),
        .core_fifo_rdy(RDY), .core_rhr_rd(rhr), .core_iir_rd(iir),
        .core_lsr_rd(lsr), .core_msr_rd(msr), .core_thr_wr(thr),
        .core_fcr_wr(fcr), .core_wdata(core_wdata), .lcr_o(lcr_o),
        .mcr_o(mcr_o), .efr_o(efr_o), .ier_o(ier_o), .div_o(div_o),
        .xon_o(xon_o), .xoff_o(xoff_o), .tcr_o(tcr_o), .tlr_o(tlr_o));

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit key();  return m_lcr == 8'hBF; endfunction
    function automatic bit tcrb(); return m_efr[4] && m_mcr[6]; endfunction

    // Expected read byte, strobe vector and requirement tag per address.
    task automatic exp_rd(input int a, output logic [7:0] e,
                          output logic [5:0] s, output string t);
        s = 6'b0; t = "R2";
        case (a)
            0: if (m_lcr[7]) begin e = m_dll; t = "R4"; end
               else begin e = RX; s = 6'b100000; end
            1: if (m_lcr[7]) begin e = m_dlm; t = "R4"; end else e = m_ier;
            2: if (key()) begin e = m_efr; t = "R5"; end
               else begin e = IIRV; s = 6'b010000; end
            3: begin e = m_lcr; t = "R10"; end
            4: if (key()) begin e = m_ch[0]; t = "R5"; end else e = m_mcr;
            5: if (key()) begin e = m_ch[1]; t = "R5"; end
               else begin e = LSRV; s = 6'b001000; end
            6: if (key()) begin e = m_ch[2]; t = "R5"; end
               else if (tcrb()) begin e = m_tcr; t = "R6"; end
               else begin e = MSRV; s = 6'b000100; end
            default:
               if (key()) begin e = m_ch[3]; t = "R5"; end
               else if (tcrb()) begin e = m_tlr; t = "R6"; end
               else if (m_mcr[2] && !m_mcr[4]) begin e = RDY; t = "R8"; end
               else e = m_spr;
        endcase
    endtask

    task automatic do_rd(input int a);
        logic [7:0] e; logic [5:0] s; string t;
        @(negedge clk); cs = 1; rd_en = 1; wr_en = 0; addr = 3'(a);
        #2;
        exp_rd(a, e, s, t);
        check(rdata == e, t, 16'(rdata), 16'(e));
        check(strb == s, "R9", 16'(strb), 16'(s));
        @(posedge clk); #1; rd_en = 0; cs = 0;
    endtask

    task automatic do_wr(input int a, input logic [7:0] d);
        logic [5:0] s;
        s = 6'b0;
        @(negedge clk); cs = 1; wr_en = 1; rd_en = 0; addr = 3'(a); wdata = d;
        #2;
        case (a)
            0: if (m_lcr[7]) m_dll = d; else s = 6'b000010;
            1: if (m_lcr[7]) m_dlm = d; else m_ier = d;
            2: if (key()) m_efr = d; else s = 6'b000001;
            3: m_lcr = d;
            4: if (key()) m_ch[0] = d;
               else m_mcr = {(m_efr[4] ? d[7] : m_mcr[7]), d[6:0]};
            5: if (key()) m_ch[1] = d;
            6: if (key()) m_ch[2] = d; else if (tcrb()) m_tcr = d;
            default: if (key()) m_ch[3] = d; else if (tcrb()) m_tlr = d;
                     else m_spr = d;
        endcase
        check(strb == s, "R3", 16'(strb), 16'(s));
        if (s != 0) check(core_wdata == d, "R3", 16'(core_wdata), 16'(d));
        @(posedge clk); #1; wr_en = 0; cs = 0;
    endtask

    task automatic ports_chk();
        check(lcr_o == m_lcr, "R11", 16'(lcr_o), 16'(m_lcr));
        check(mcr_o == m_mcr, "R11", 16'(mcr_o), 16'(m_mcr));
        check(efr_o == m_efr, "R11", 16'(efr_o), 16'(m_efr));
        check(ier_o == m_ier, "R11", 16'(ier_o), 16'(m_ier));
        check(div_o == {m_dlm, m_dll}, "R11", div_o, {m_dlm, m_dll});
        check(xon_o == {m_ch[1], m_ch[0]}, "R11", xon_o, {m_ch[1], m_ch[0]});
        check(xoff_o == {m_ch[3], m_ch[2]}, "R11", xoff_o, {m_ch[3], m_ch[2]});
        check(tcr_o == m_tcr, "R11", 16'(tcr_o), 16'(m_tcr));
        check(tlr_o == m_tlr, "R11", 16'(tlr_o), 16'(m_tlr));
    endtask

    // Writes every address but 3 (high to low), then reads all eight.
    task automatic sweep(input logic [7:0] seed);
        for (int a = 7; a >= 0; a--)
            if (a != 3) do_wr(a, seed ^ 8'(a * 8'h11));
        for (int a = 0; a < 8; a++) do_rd(a);
        ports_chk();
    endtask

    task automatic read_all();
        for (int a = 0; a < 8; a++) do_rd(a);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset values and idle read
        #2;
        check(rdata == 8'h00, "R1", 16'(rdata), 16'h0);
        check(strb == 6'b0, "R1", 16'(strb), 16'h0);
        ports_chk();
        read_all();
        // default bank; MCR becomes 64h so the FIFO-ready read applies (R8)
        do_wr(3, 8'h03); sweep(8'h20);
        // divisor bank, then back to default to see nothing leaked (R4)
        do_wr(3, 8'h83); sweep(8'h31);
        do_wr(3, 8'h03); read_all();
        // key bank; EFR bit 4 gets set while MCR bit 6 is 1 (R5 precedence)
        do_wr(3, 8'hBF); sweep(8'h5A); read_all();
        // TCR/TLR bank, then MCR rewritten with bit 7 allowed (R6)
        do_wr(3, 8'h03); read_all(); sweep(8'hC3);
        do_wr(3, 8'h80); read_all();
        // R7: clear enhanced bit, try to clear MCR bit 7
        do_wr(3, 8'hBF); do_wr(2, 8'h00);
        do_wr(3, 8'h03); do_wr(4, 8'h04);
        check(mcr_o == 8'h84, "R7", 16'(mcr_o), 16'h84);
        do_wr(4, 8'h7F); read_all();
        // R7: enhanced bit set again, bit 7 now writable
        do_wr(3, 8'hBF); do_wr(2, 8'h10);
        do_wr(3, 8'h03); do_wr(4, 8'h00);
        check(mcr_o == 8'h00, "R7", 16'(mcr_o), 16'h00);
        read_all(); ports_chk();
        // R9: simultaneous read and write counts as a write
        @(negedge clk); cs = 1; rd_en = 1; wr_en = 1; addr = 3'd0; wdata = 8'h99;
        #2 check(strb == 6'b000010, "R9", 16'(strb), 16'h02);
        @(posedge clk); #1 cs = 0; rd_en = 0; wr_en = 0;
        // R1: chip select low with strobes asserted
        @(negedge clk); rd_en = 1; addr = 3'd0;
        #2 check(rdata == 8'h00 && strb == 6'b0, "R1", {8'(strb), rdata}, 16'h0);
        rd_en = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule